// File: doc/BRIEF.md
# Register Pointer Auto-Increment Controller

This block is the target-side register pointer for a byte-oriented serial register bus. It sits between a byte-level bus target engine, which reports start conditions and individual data bytes, and a register file of 256 byte-wide addresses. It holds the current register index and a byte sub-offset. From these it drives the register file's select lines, its write enable and write data, and the byte returned to the bus master on reads.

In a write transfer, the first data byte loads the register index, and every byte after it is data. A read transfer continues from the index left in place by an earlier transfer. Most registers are one byte wide, and for them the index steps by one after each data byte. A fixed set of multibyte registers instead holds the index steady while the sub-offset walks through their internal bytes. One single-byte register is also held in place. Accesses past the end of a multibyte register, and writes to the read-only address range, are absorbed without any effect on the bus.

Top module: `rptr_top`

## Requirements
- R1: After reset, reg_sel and sub_sel are 0, rf_we is 0, and the next write transfer takes its first byte as the index. A read transfer started straight after reset reads register 0x00.
- R2: The first wr_stb byte after a write start (xfer_start with xfer_read=0) loads reg_sel with that byte and clears sub_sel. rf_we stays 0 for that byte.
- R3: For an ordinary register (any address not named in R4 or R5), each data byte (rd_stb, or wr_stb after the index byte) advances reg_sel by one, wrapping from 0xFF to 0x00. sub_sel stays 0.
- R4: At the multibyte addresses 0x29, 0x2D, 0x4F, 0x61 and 0x7F, data bytes leave reg_sel unchanged. sub_sel advances by one per byte and saturates at 0xFF.
- R5: At address 0x60, data bytes leave reg_sel unchanged and sub_sel at 0.
- R6: The multibyte lengths are 5 bytes (0x29), 4 bytes (0x2D), 8 bytes (0x4F), 200 bytes (0x61) and 16 bytes (0x7F).
- R7: When sub_sel is at or beyond the length of the selected multibyte register, rd_byte is 0xFF and rf_we stays 0 for write bytes. The pointer still advances as in R4.
- R8: Every xfer_start resets sub_sel to 0 and keeps reg_sel. A strobe in the same cycle as xfer_start is ignored.
- R9: Write bytes addressed to the read-only range RO_BASE..RO_LIMIT (default 0x00..0x0F) give rf_we=0. The pointer still advances. For every other in-range data write byte, rf_we is 1 and rf_wdata equals wr_byte.
- R10: Within range, rd_byte equals rf_rdata, which is the register file's byte at reg_sel/sub_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse at a start or repeated start |
| xfer_read | input | 1 | Direction of the starting transfer, 1 = read |
| rd_stb | input | 1 | One read byte is being taken by the master |
| wr_stb | input | 1 | One written byte is present on wr_byte |
| wr_byte | input | 8 | Byte received from the master |
| rf_rdata | input | 8 | Register file byte at reg_sel/sub_sel |
| reg_sel | output | 8 | Current register index |
| sub_sel | output | 8 | Byte offset inside a multibyte register |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 8 | Register file write data |
| rd_byte | output | 8 | Byte returned to the master |

## Verification
The bench builds the block with its default parameters: the full 8-bit address space and the read-only range 0x00..0x0F. It sweeps every one of the 256 start indices through a write of three data bytes followed by a read of three bytes. This covers the 0xFF-to-0x00 wrap, the step from an ordinary register into 0x60, the read-only boundary and every multibyte entry. Each multibyte register is then written and read two bytes past its length, which covers the full 200-byte window and the 0xFF fill beyond every length.

// File: rtl/rptr_pkg.sv
// Package: shared types and the fixed address map of the pointer controller.
// Assumes 8-bit addresses and data; the multibyte list is fixed by the map.
package rptr_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int SUB_W  = 8;

    typedef enum logic [1:0] {
        RK_STEP   = 2'd0,   // ordinary byte register, index advances
        RK_HOLD   = 2'd1,   // single byte, index held
        RK_STREAM = 2'd2    // multibyte, sub-offset walks
    } reg_kind_t;

    // Classify one register address.
    function automatic reg_kind_t kind_of(input logic [ADDR_W-1:0] a);
        case (a)
            8'h29, 8'h2D, 8'h4F, 8'h61, 8'h7F: return RK_STREAM;
            8'h60:                             return RK_HOLD;
            default:                           return RK_STEP;
        endcase
    endfunction

    // Length in bytes of a multibyte register (1 for all others).
    function automatic logic [SUB_W-1:0] length_of(input logic [ADDR_W-1:0] a);
        case (a)
            8'h29:   return 8'd5;
            8'h2D:   return 8'd4;
            8'h4F:   return 8'd8;
            8'h61:   return 8'd200;
            8'h7F:   return 8'd16;
            default: return 8'd1;
        endcase
    endfunction
endpackage

// File: rtl/rptr_decode.sv
// Module: address decoder. Maps the current index to its kind, its length
// and its read-only flag. Purely combinational; assumes RO_BASE <= RO_LIMIT.
module rptr_decode
    import rptr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RO_BASE  = 8'h00,
    parameter logic [ADDR_W-1:0] RO_LIMIT = 8'h0F
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_t         kind,
    output logic [SUB_W-1:0]  len,
    output logic              ro
);
    // Decode the address through the package map and the read-only range.
    always_comb begin
        kind = kind_of(addr);
        len  = length_of(addr);
        ro   = (addr >= RO_BASE) && (addr <= RO_LIMIT);
    end
endmodule

// File: rtl/rptr_core.sv
// Module: pointer state. Holds the index, the sub-offset and the
// "next write byte is the index" flag. Assumes the strobes are single-cycle
// pulses; a start in the same cycle overrides any strobe.
module rptr_core
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  reg_kind_t         kind,
    output logic [ADDR_W-1:0] idx,
    output logic [SUB_W-1:0]  sub,
    output logic              need_idx,
    output logic              data_byte
);
    logic idx_load;

    // Qualify the strobes: index load versus data byte.
    always_comb begin
        idx_load  = wr_stb && need_idx && !start;
        data_byte = !start && (rd_stb || (wr_stb && !need_idx));
    end

    // Update the pointer on starts, index bytes and data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            sub      <= '0;
            need_idx <= 1'b1;
        end else if (start) begin
            sub      <= '0;
            need_idx <= !start_rd;
        end else if (idx_load) begin
            idx      <= wr_data;
            sub      <= '0;
            need_idx <= 1'b0;
        end else if (data_byte) begin
            case (kind)
                RK_STEP:   idx <= idx + 1'b1;
                RK_STREAM: if (sub != '1) sub <= sub + 1'b1;
                default:   ;
            endcase
        end
    end

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && kind == RK_STEP) |=> (idx == ADDR_W'($past(idx) + 1'b1)));
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && kind != RK_STEP) |=> $stable(idx));
    assert_hold_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_byte && kind == RK_HOLD) |=> $stable(sub));
    assert_sub_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (sub == '0));
    assert_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && need_idx && !start) |=> (idx == $past(wr_data) && !need_idx));
endmodule

// File: rtl/rptr_gate.sv
// Module: access gate. Forms the write enable and the returned read byte.
// Assumes rf_rdata is the register file byte at the current index/offset.
module rptr_gate
    import rptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_byte,
    input  logic              wr_stb,
    input  reg_kind_t         kind,
    input  logic [SUB_W-1:0]  len,
    input  logic [SUB_W-1:0]  sub,
    input  logic              ro,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [DATA_W-1:0] rd_data
);
    logic oor;

    // Detect offsets beyond the end of a multibyte register and gate access.
    always_comb begin
        oor      = (kind == RK_STREAM) && (sub >= len);
        rf_we    = data_byte && wr_stb && !ro && !oor;
        rf_wdata = wr_data;
        rd_data  = oor ? '1 : rf_rdata;
    end

    assert_ro_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !ro);
    assert_oor_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_STREAM && sub >= len) |-> !rf_we);
endmodule

// File: rtl/rptr_top.sv
// Module: top of the register pointer controller. Connects the decoder,
// the pointer state and the access gate. Assumes one byte event per cycle.
module rptr_top
    import rptr_pkg::*;
#(
    parameter logic [7:0] RO_BASE  = 8'h00,
    parameter logic [7:0] RO_LIMIT = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_start,
    input  logic       xfer_read,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wr_byte,
    input  logic [7:0] rf_rdata,
    output logic [7:0] reg_sel,
    output logic [7:0] sub_sel,
    output logic       rf_we,
    output logic [7:0] rf_wdata,
    output logic [7:0] rd_byte
);
    reg_kind_t        kind;
    logic [SUB_W-1:0] len;
    logic             ro;
    logic             need_idx;
    logic             data_byte;

    rptr_decode #(.RO_BASE(RO_BASE), .RO_LIMIT(RO_LIMIT)) u_dec (
        .addr(reg_sel), .kind(kind), .len(len), .ro(ro)
    );

    rptr_core u_core (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_rd(xfer_read),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_byte), .kind(kind),
        .idx(reg_sel), .sub(sub_sel), .need_idx(need_idx), .data_byte(data_byte)
    );

    rptr_gate u_gate (
        .clk(clk), .rst_n(rst_n), .data_byte(data_byte), .wr_stb(wr_stb),
        .kind(kind), .len(len), .sub(sub_sel), .ro(ro), .rf_rdata(rf_rdata),
        .wr_data(wr_byte), .rf_we(rf_we), .rf_wdata(rf_wdata), .rd_data(rd_byte)
    );
endmodule

// File: tb/rptr_top_test.sv
`timescale 1ns/1ps
module rptr_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_start = 1'b0, xfer_read = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wr_byte = 8'h00;
    logic [7:0] rf_rdata, reg_sel, sub_sel, rf_wdata, rd_byte;
    logic       rf_we;
    int         errs = 0, checks = 0;
    logic [7:0] m_idx, m_sub;

    always #2.5 clk = ~clk;

    // Model register file: byte value computed from select and offset.
    assign rf_rdata = 8'(reg_sel + 8'(sub_sel * 3) + 8'h11);

    rptr_top uut (.clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
        .xfer_read(xfer_read), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .wr_byte(wr_byte), .rf_rdata(rf_rdata), .reg_sel(reg_sel),
        .sub_sel(sub_sel), .rf_we(rf_we), .rf_wdata(rf_wdata), .rd_byte(rd_byte));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_kind(input logic [7:0] a); // 0 step,1 hold,2 stream
        if (a == 8'h60) return 1;
        if (a == 8'h29 || a == 8'h2D || a == 8'h4F || a == 8'h61 || a == 8'h7F) return 2;
        return 0;
    endfunction

    function automatic int m_len(input logic [7:0] a);
        case (a)
            8'h29: return 5;   8'h2D: return 4;  8'h4F: return 8;
            8'h61: return 200; 8'h7F: return 16; default: return 1;
        endcase
    endfunction

    function automatic bit m_oor();
        return m_kind(m_idx) == 2 && int'(m_sub) >= m_len(m_idx);
    endfunction

    task automatic m_step();
        case (m_kind(m_idx))
            0: m_idx = m_idx + 8'd1;
            2: if (m_sub != 8'hFF) m_sub = m_sub + 8'd1;
            default: ;
        endcase
    endtask

    task automatic check_ptr(input string req);
        chk({req, " reg_sel"}, reg_sel, m_idx);
        chk({req, " sub_sel"}, sub_sel, m_sub);
    endtask

    task automatic do_start(input logic rd);
        @(negedge clk); xfer_start = 1'b1; xfer_read = rd;
        @(posedge clk); #1 xfer_start = 1'b0;
        m_sub = 8'd0;
        @(negedge clk); check_ptr("R8 start");
    endtask

    task automatic do_index(input logic [7:0] a);
        @(negedge clk); wr_stb = 1'b1; wr_byte = a;
        #0.5 chk("R2 no write on index byte", rf_we, 0);
        @(posedge clk); #1 wr_stb = 1'b0;
        m_idx = a; m_sub = 8'd0;
        @(negedge clk); check_ptr("R2 index load");
    endtask

    task automatic do_write(input logic [7:0] d);
        bit exp_we;
        @(negedge clk); wr_stb = 1'b1; wr_byte = d;
        exp_we = !m_oor() && !(m_idx <= 8'h0F);
        #0.5;
        if (m_oor()) chk("R7 write past end dropped", rf_we, 0);
        else chk("R9 write enable", rf_we, int'(exp_we));
        if (exp_we) chk("R9 write data", rf_wdata, d);
        @(posedge clk); #1 wr_stb = 1'b0;
        m_step();
        @(negedge clk); check_ptr("R3/R4/R5 advance after write");
    endtask

    task automatic do_read();
        int expv;
        @(negedge clk); rd_stb = 1'b1;
        expv = m_oor() ? 8'hFF : int'(8'(m_idx + 8'(m_sub * 3) + 8'h11));
        #0.5;
        if (m_oor()) chk("R7 read past end", rd_byte, expv);
        else chk("R10 read data", rd_byte, expv);
        @(posedge clk); #1 rd_stb = 1'b0;
        m_step();
        @(negedge clk); check_ptr("R3/R4/R5 advance after read");
    endtask

    initial begin
        #(200000 * 5);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        m_idx = 8'd0; m_sub = 8'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check_ptr("R1 reset");
        chk("R1 reset rf_we", rf_we, 0);
        // R1: read straight after reset starts at register 0x00
        do_start(1'b1);
        do_read();
        chk("R1 read from 0x00 advanced to", reg_sel, 1);
        // R1: first write byte after reset is the index
        do_start(1'b0);
        do_index(8'h42);
        // Sweep every start index: 3 writes, then 3 reads (R3 wrap, R5, R9)
        for (int a = 0; a < 256; a++) begin
            logic [7:0] keep;
            do_start(1'b0);
            do_index(8'(a));
            for (int k = 0; k < 3; k++) do_write(8'(a * 5 + k));
            keep = m_idx;
            do_start(1'b1);
            chk("R8 index kept over start", reg_sel, keep);
            for (int k = 0; k < 3; k++) do_read();
        end
        // R6: walk each multibyte register two bytes past its length
        for (int r = 0; r < 5; r++) begin
            logic [7:0] a;
            case (r)
                0: a = 8'h29; 1: a = 8'h2D; 2: a = 8'h4F;
                3: a = 8'h61; default: a = 8'h7F;
            endcase
            do_start(1'b0);
            do_index(a);
            for (int k = 0; k < m_len(a) + 2; k++) do_write(8'(k));
            chk("R6 length reached on write", sub_sel, m_len(a) + 2);
            do_start(1'b1);
            for (int k = 0; k < m_len(a) + 2; k++) do_read();
            chk("R4 index frozen on multibyte", reg_sel, a);
        end
        // R8: strobe together with start is ignored
        do_start(1'b0);
        do_index(8'h30);
        @(negedge clk); xfer_start = 1'b1; xfer_read = 1'b1; rd_stb = 1'b1;
        @(posedge clk); #1 xfer_start = 1'b0; rd_stb = 1'b0;
        @(negedge clk); chk("R8 strobe with start ignored", reg_sel, 8'h30);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule